// File: doc/BRIEF.md
# Vector Carry-Chain Element Engine

This block runs an element-wise add-with-carry or subtract-with-borrow across register groups held in a private file of 32 vector registers. A single start request supplies the whole command:
- the operation;
- the destination base and the first source base;
- the second operand, which is either another source group base or a 64-bit scalar;
- the element width and the group size;
- the first element index and the element count limit.

The engine then works through one element per clock. It reads both operands and the matching carry or borrow bit from register 0, and writes the width-truncated result into the destination group.

Register 0 is the per-element carry/borrow mask, so it can never be a destination. A request naming it, or naming a badly aligned group, or asking for more elements than the group holds, is turned away with a one-cycle error pulse and leaves the file untouched. When a sweep ends, three signals pulse together for one cycle: completion, state-dirty and start-index-clear. A side port lets surrounding logic, or a bench, load and inspect whole registers while the engine is idle.

Top module: `vcarry_engine`

## Requirements
- R1: After reset, all 32 registers read as zero, and busy, done, error, dirty and start-index-clear are low.
- R2: Elements with index from the start index up to, but not including, the limit are written. All other bits of every register keep their value.
- R3: The add operation (operation code 0) stores (a + b + c) mod 2^SEW. Width code 0/1/2/3 selects SEW = 8/16/32/64. The value c is the mask bit of the element when the carry-enable input is 1, and zero otherwise.
- R4: The subtract operation (operation code 1) stores (a - b - m) mod 2^SEW. The value m is always the mask bit of the element, whatever the carry-enable input holds.
- R5: Operand b comes from the second source group when the scalar-select input is 0. When it is 1, b is the low SEW bits of the scalar input.
- R6: Element i of a group with base B occupies register B + (i*SEW)/VLEN, at bit offset (i*SEW) mod VLEN. Its mask bit is bit i of register 0, which is bit i mod 8 of byte i/8.
- R7: A request with destination 0 is rejected. The error output is high for the one cycle after the request edge, busy stays low, and no register changes.
- R8: A request is rejected in the same way as in R7 when any used base is not a multiple of the group size 2^g (g = group code 0..3), or when the limit exceeds 2^g*VLEN/SEW.
- R9: After an accepted request, busy is high from the next cycle. One element is written per clock. Done, dirty and start-index-clear pulse together for one cycle, max(N,1) clocks after the request edge, where N is the number of elements. Busy is low in that cycle.
- R10: When the start index is at or above the limit, no register changes, and the done, dirty and start-index-clear pulse still occurs after one clock.
- R11: A start request that arrives while busy is ignored. It causes no error and does not change the running sweep.
- R12: A side-port write takes effect only while idle. While busy it is dropped and the target register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request |
| op_i | input | 1 | 0 add-with-carry, 1 subtract-with-borrow |
| carry_en_i | input | 1 | Add form: take carry from register 0 |
| vd_i | input | 5 | Destination group base |
| vs2_i | input | 5 | First source group base |
| vs1_i | input | 5 | Second source group base |
| use_scalar_i | input | 1 | Take operand b from scalar_i |
| scalar_i | input | 64 | Scalar operand |
| sew_i | input | 2 | Element width code |
| grp_i | input | 2 | Group size code (2^grp_i registers) |
| vstart_i | input | IDX_W | First element index |
| vl_i | input | IDX_W | Element limit (exclusive) |
| tp_we_i | input | 1 | Side-port register write |
| tp_addr_i | input | 5 | Side-port register select |
| tp_wdata_i | input | VLEN | Side-port write data |
| tp_rdata_o | output | VLEN | Side-port read data |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Rejected-request pulse |
| dirty_o | output | 1 | Vector-state-dirty pulse |
| vstart_clr_o | output | 1 | Start-index-clear pulse |

## Verification
The assertions assume that reset is held from time zero until the first edges have passed. They also assume that a start request is a clean level, sampled only at the clock edge. Given those, they require four things:
- The register-0 mask never moves during a sweep.
- No element write ever targets register 0.
- Each rejection follows an idle-time request.
- Completion coincides with the fall of busy.

The stimulus drives every input at the falling edge. Accepted commands keep the limit within group capacity and the bases aligned. Out-of-range values appear only in the dedicated rejection scenarios, so the mask index used for the carry always lies inside register 0.

// File: rtl/vcarry_pkg.sv
package vcarry_pkg;

    localparam int NREG   = 32;
    localparam int REG_AW = 5;
    localparam int ELEM_W = 64;

    typedef enum logic {
        OP_ADC = 1'b0,
        OP_SBC = 1'b1
    } vc_op_e;

    typedef enum logic [1:0] {
        SEW_8  = 2'd0,
        SEW_16 = 2'd1,
        SEW_32 = 2'd2,
        SEW_64 = 2'd3
    } vc_sew_e;

    typedef struct packed {
        vc_op_e              op;
        logic                carry_en;
        logic [REG_AW-1:0]   vd;
        logic [REG_AW-1:0]   vs2;
        logic [REG_AW-1:0]   vs1;
        logic                use_scalar;
        logic [ELEM_W-1:0]   scalar;
        vc_sew_e             sew;
        logic [1:0]          grp_log2;
    } vc_cmd_t;

    function automatic logic [ELEM_W-1:0] sew_mask(vc_sew_e s);
        case (s)
            SEW_8:   return 64'h0000_0000_0000_00FF;
            SEW_16:  return 64'h0000_0000_0000_FFFF;
            SEW_32:  return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [2:0] sew_shift(vc_sew_e s);
        return 3'd3 + {1'b0, s};
    endfunction

endpackage

// File: rtl/vcarry_locate.sv
module vcarry_locate
    import vcarry_pkg::*;
#(
    parameter int VLEN     = 128,
    parameter int LOG_VLEN = $clog2(VLEN),
    parameter int IDX_W    = $clog2(VLEN + 1)
) (
    input  logic [IDX_W-1:0]    idx_i,
    input  vc_sew_e             sew_i,
    output logic [REG_AW-1:0]   reg_ofs_o,
    output logic [LOG_VLEN-1:0] bit_off_o
);
    localparam int PW = LOG_VLEN + REG_AW;

    logic [PW-1:0] pos;

    always_comb begin
        pos       = PW'(idx_i) << sew_shift(sew_i);
        reg_ofs_o = pos[PW-1:LOG_VLEN];
        bit_off_o = pos[LOG_VLEN-1:0];
    end
endmodule

// File: rtl/vcarry_alu.sv
module vcarry_alu
    import vcarry_pkg::*;
(
    input  vc_op_e            op_i,
    input  vc_sew_e           sew_i,
    input  logic [ELEM_W-1:0] a_i,
    input  logic [ELEM_W-1:0] b_i,
    input  logic              cin_i,
    output logic [ELEM_W-1:0] res_o
);
    logic [ELEM_W-1:0] sum;
    logic [ELEM_W-1:0] diff;

    always_comb begin
        sum   = a_i + b_i + ELEM_W'(cin_i);
        diff  = a_i - b_i - ELEM_W'(cin_i);
        res_o = ((op_i == OP_SBC) ? diff : sum) & sew_mask(sew_i);
    end
endmodule

// File: rtl/vcarry_rf.sv
module vcarry_rf
    import vcarry_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] ra_addr_i,
    output logic [VLEN-1:0]   ra_data_o,
    input  logic [REG_AW-1:0] rb_addr_i,
    output logic [VLEN-1:0]   rb_data_o,
    input  logic [REG_AW-1:0] rt_addr_i,
    output logic [VLEN-1:0]   rt_data_o,
    output logic [VLEN-1:0]   v0_data_o,
    input  logic              w_en_i,
    input  logic [REG_AW-1:0] w_addr_i,
    input  logic [VLEN-1:0]   w_data_i,
    input  logic [VLEN-1:0]   w_mask_i
);
    logic [VLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) begin
                regs[r] <= '0;
            end
        end else if (w_en_i) begin
            regs[w_addr_i] <= (regs[w_addr_i] & ~w_mask_i) | (w_data_i & w_mask_i);
        end
    end

    assign ra_data_o = regs[ra_addr_i];
    assign rb_data_o = regs[rb_addr_i];
    assign rt_data_o = regs[rt_addr_i];
    assign v0_data_o = regs[0];
endmodule

// File: rtl/vcarry_seq.sv
module vcarry_seq
    import vcarry_pkg::*;
#(
    parameter int VLEN  = 128,
    parameter int IDX_W = $clog2(VLEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  vc_cmd_t          cmd_i,
    input  logic [IDX_W-1:0] vstart_i,
    input  logic [IDX_W-1:0] vl_i,
    output vc_cmd_t          cmd_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             we_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic             dirty_o,
    output logic             vclr_o
);
    localparam int CW = IDX_W + 4;

    logic [REG_AW-1:0] grp_m;
    logic [CW-1:0]     cap;
    logic              bad;
    logic [IDX_W-1:0]  vl_q;
    logic [IDX_W:0]    idx_nx;

    always_comb begin
        grp_m = REG_AW'((6'd1 << cmd_i.grp_log2) - 6'd1);
        cap   = (CW'(VLEN) << cmd_i.grp_log2) >> sew_shift(cmd_i.sew);
        bad   = (cmd_i.vd == '0)
              || ((cmd_i.vd  & grp_m) != '0)
              || ((cmd_i.vs2 & grp_m) != '0)
              || (!cmd_i.use_scalar && ((cmd_i.vs1 & grp_m) != '0))
              || (CW'(vl_i) > cap);
        idx_nx = {1'b0, idx_o} + 1'b1;
        we_o   = busy_o && (idx_o < vl_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o   <= '0;
            idx_o   <= '0;
            vl_q    <= '0;
            busy_o  <= 1'b0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
            dirty_o <= 1'b0;
            vclr_o  <= 1'b0;
        end else begin
            done_o  <= 1'b0;
            err_o   <= 1'b0;
            dirty_o <= 1'b0;
            vclr_o  <= 1'b0;
            if (!busy_o) begin
                if (start_i) begin
                    if (bad) begin
                        err_o <= 1'b1;
                    end else begin
                        busy_o <= 1'b1;
                        cmd_o  <= cmd_i;
                        idx_o  <= vstart_i;
                        vl_q   <= vl_i;
                    end
                end
            end else begin
                idx_o <= idx_nx[IDX_W-1:0];
                if (idx_nx >= {1'b0, vl_q}) begin
                    busy_o  <= 1'b0;
                    done_o  <= 1'b1;
                    dirty_o <= 1'b1;
                    vclr_o  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vcarry_engine.sv
module vcarry_engine
    import vcarry_pkg::*;
#(
    parameter int VLEN     = 128,
    parameter int LOG_VLEN = $clog2(VLEN),
    parameter int IDX_W    = $clog2(VLEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             op_i,
    input  logic             carry_en_i,
    input  logic [4:0]       vd_i,
    input  logic [4:0]       vs2_i,
    input  logic [4:0]       vs1_i,
    input  logic             use_scalar_i,
    input  logic [63:0]      scalar_i,
    input  logic [1:0]       sew_i,
    input  logic [1:0]       grp_i,
    input  logic [IDX_W-1:0] vstart_i,
    input  logic [IDX_W-1:0] vl_i,
    input  logic             tp_we_i,
    input  logic [4:0]       tp_addr_i,
    input  logic [VLEN-1:0]  tp_wdata_i,
    output logic [VLEN-1:0]  tp_rdata_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic             dirty_o,
    output logic             vstart_clr_o
);
    vc_cmd_t             cmd_in;
    vc_cmd_t             cmd_q;
    logic [IDX_W-1:0]    idx_q;
    logic                eng_we;
    logic [REG_AW-1:0]   reg_ofs;
    logic [LOG_VLEN-1:0] bit_off;
    logic [REG_AW-1:0]   ra_addr;
    logic [REG_AW-1:0]   rb_addr;
    logic [REG_AW-1:0]   wr_addr;
    logic [VLEN-1:0]     ra_data;
    logic [VLEN-1:0]     rb_data;
    logic [VLEN-1:0]     v0_data;
    logic [ELEM_W-1:0]   el_mask;
    logic [ELEM_W-1:0]   opa;
    logic [ELEM_W-1:0]   opb;
    logic                cin;
    logic [ELEM_W-1:0]   res;
    logic                rf_we;
    logic [REG_AW-1:0]   rf_waddr;
    logic [VLEN-1:0]     rf_wdata;
    logic [VLEN-1:0]     rf_wmask;

    always_comb begin
        cmd_in.op         = vc_op_e'(op_i);
        cmd_in.carry_en   = carry_en_i;
        cmd_in.vd         = vd_i;
        cmd_in.vs2        = vs2_i;
        cmd_in.vs1        = vs1_i;
        cmd_in.use_scalar = use_scalar_i;
        cmd_in.scalar     = scalar_i;
        cmd_in.sew        = vc_sew_e'(sew_i);
        cmd_in.grp_log2   = grp_i;
    end

    vcarry_seq #(.VLEN(VLEN), .IDX_W(IDX_W)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .cmd_i    (cmd_in),
        .vstart_i (vstart_i),
        .vl_i     (vl_i),
        .cmd_o    (cmd_q),
        .idx_o    (idx_q),
        .we_o     (eng_we),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .err_o    (err_o),
        .dirty_o  (dirty_o),
        .vclr_o   (vstart_clr_o)
    );

    vcarry_locate #(.VLEN(VLEN), .LOG_VLEN(LOG_VLEN), .IDX_W(IDX_W)) loc_i (
        .idx_i     (idx_q),
        .sew_i     (cmd_q.sew),
        .reg_ofs_o (reg_ofs),
        .bit_off_o (bit_off)
    );

    always_comb begin
        ra_addr = cmd_q.vs2 + reg_ofs;
        rb_addr = cmd_q.vs1 + reg_ofs;
        wr_addr = cmd_q.vd  + reg_ofs;
        el_mask = sew_mask(cmd_q.sew);
        opa     = ELEM_W'(ra_data >> bit_off) & el_mask;
        opb     = cmd_q.use_scalar ? (cmd_q.scalar & el_mask)
                                   : (ELEM_W'(rb_data >> bit_off) & el_mask);
        cin     = ((cmd_q.op == OP_SBC) || cmd_q.carry_en) ? v0_data[idx_q[LOG_VLEN-1:0]] : 1'b0;
    end

    vcarry_alu alu_i (
        .op_i  (cmd_q.op),
        .sew_i (cmd_q.sew),
        .a_i   (opa),
        .b_i   (opb),
        .cin_i (cin),
        .res_o (res)
    );

    always_comb begin
        if (eng_we) begin
            rf_we    = 1'b1;
            rf_waddr = wr_addr;
            rf_wdata = VLEN'(res) << bit_off;
            rf_wmask = VLEN'(el_mask) << bit_off;
        end else begin
            rf_we    = tp_we_i && !busy_o;
            rf_waddr = tp_addr_i;
            rf_wdata = tp_wdata_i;
            rf_wmask = '1;
        end
    end

    vcarry_rf #(.VLEN(VLEN)) rf_i (
        .clk       (clk),
        .rst       (rst),
        .ra_addr_i (ra_addr),
        .ra_data_o (ra_data),
        .rb_addr_i (rb_addr),
        .rb_data_o (rb_data),
        .rt_addr_i (tp_addr_i),
        .rt_data_o (tp_rdata_o),
        .v0_data_o (v0_data),
        .w_en_i    (rf_we),
        .w_addr_i  (rf_waddr),
        .w_data_i  (rf_wdata),
        .w_mask_i  (rf_wmask)
    );
endmodule

// File: rtl/vcarry_engine_chk.sv
module vcarry_engine_chk #(
    parameter int VLEN = 128
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            err,
    input logic            dirty,
    input logic            vclr,
    input logic            eng_we,
    input logic [4:0]      wr_addr,
    input logic [VLEN-1:0] v0_data
);
    // R9: completion pulses coincide with busy falling
    a_r9_done_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && dirty && vclr));

    // R9: completion lasts one cycle and is seen while idle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7: the mask register is never an element destination
    a_r7_no_v0_write: assert property (@(posedge clk) disable iff (rst)
        eng_we |-> (wr_addr != 5'd0));

    // R7: a rejection only follows a request made while idle
    a_r7_err_from_idle: assert property (@(posedge clk) disable iff (rst)
        err |-> ($past(start) && !$past(busy) && !busy));

    // R4: the carry/borrow mask is steady through a sweep
    a_r4_mask_steady: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(v0_data));
endmodule

bind vcarry_engine vcarry_engine_chk #(.VLEN(VLEN)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start_i),
    .busy    (busy_o),
    .done    (done_o),
    .err     (err_o),
    .dirty   (dirty_o),
    .vclr    (vstart_clr_o),
    .eng_we  (eng_we),
    .wr_addr (wr_addr),
    .v0_data (v0_data)
);

// File: tb/vcarry_engine_tb_top.sv
module vcarry_engine_tb_top;
    localparam int VLEN = 128;
    localparam int IW   = $clog2(VLEN + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic            op = 1'b0;
    logic            carry_en = 1'b0;
    logic [4:0]      vd = '0, vs2 = '0, vs1 = '0;
    logic            use_scalar = 1'b0;
    logic [63:0]     scalar = '0;
    logic [1:0]      sew = '0, grp = '0;
    logic [IW-1:0]   vstart = '0, vl = '0;
    logic            tp_we = 1'b0;
    logic [4:0]      tp_addr = '0;
    logic [VLEN-1:0] tp_wdata = '0;
    logic [VLEN-1:0] tp_rdata;
    logic            busy, done, err, dirty, vclr;

    logic [VLEN-1:0] model [32];
    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    vcarry_engine #(.VLEN(VLEN)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .op_i(op), .carry_en_i(carry_en),
        .vd_i(vd), .vs2_i(vs2), .vs1_i(vs1), .use_scalar_i(use_scalar),
        .scalar_i(scalar), .sew_i(sew), .grp_i(grp), .vstart_i(vstart), .vl_i(vl),
        .tp_we_i(tp_we), .tp_addr_i(tp_addr), .tp_wdata_i(tp_wdata),
        .tp_rdata_o(tp_rdata), .busy_o(busy), .done_o(done), .err_o(err),
        .dirty_o(dirty), .vstart_clr_o(vclr)
    );

    task automatic check(input bit ok, input string tag, input string msg);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    function automatic logic [63:0] m_get(input int base, input int i, input int s);
        int w;
        int pos;
        logic [63:0] r;
        w   = 8 << s;
        pos = i * w;
        r   = 64'(model[base + pos / VLEN] >> (pos % VLEN));
        if (w < 64) r = r & ((64'd1 << w) - 64'd1);
        return r;
    endfunction

    function automatic void m_set(input int base, input int i, input int s, input logic [63:0] v);
        int w;
        int pos;
        logic [63:0] msk;
        w   = 8 << s;
        pos = i * w;
        msk = (w < 64) ? ((64'd1 << w) - 64'd1) : '1;
        model[base + pos / VLEN] = (model[base + pos / VLEN] & ~(VLEN'(msk) << (pos % VLEN)))
                                 | (VLEN'(v & msk) << (pos % VLEN));
    endfunction

    function automatic void ref_run(input bit o, input bit ce, input int d, input int s2,
                                    input int s1, input bit us, input logic [63:0] sc,
                                    input int s, input int vst, input int vln);
        logic [63:0] a, b, c, r;
        for (int i = vst; i < vln; i++) begin
            a = m_get(s2, i, s);
            b = us ? sc : m_get(s1, i, s);
            c = (o || ce) ? 64'(model[0][i]) : 64'd0;
            r = o ? (a - b - c) : (a + b + c);
            m_set(d, i, s, r);
        end
    endfunction

    task automatic tp_write(input int r, input logic [VLEN-1:0] v);
        tp_we = 1'b1; tp_addr = 5'(r); tp_wdata = v;
        @(posedge clk); @(negedge clk);
        tp_we = 1'b0;
    endtask

    task automatic preload();
        for (int r = 0; r < 32; r++) begin
            model[r] = {$urandom, $urandom, $urandom, $urandom};
            tp_write(r, model[r]);
        end
    endtask

    task automatic compare_all(input string tag);
        int bad_r;
        logic [VLEN-1:0] got, exp;
        bad_r = -1;
        got = '0;
        exp = '0;
        for (int r = 0; r < 32; r++) begin
            tp_addr = 5'(r);
            #1;
            if (tp_rdata !== model[r] && bad_r < 0) begin
                bad_r = r; got = tp_rdata; exp = model[r];
            end
        end
        check(bad_r < 0, tag, $sformatf("reg %0d actual %h expected %h", bad_r, got, exp));
    endtask

    task automatic drive(input bit o, input bit ce, input int d, input int s2, input int s1,
                         input bit us, input logic [63:0] sc, input int s, input int g,
                         input int vst, input int vln);
        op = o; carry_en = ce; vd = 5'(d); vs2 = 5'(s2); vs1 = 5'(s1);
        use_scalar = us; scalar = sc; sew = 2'(s); grp = 2'(g);
        vstart = IW'(vst); vl = IW'(vln);
    endtask

    task automatic do_op(input bit o, input bit ce, input int d, input int s2, input int s1,
                         input bit us, input logic [63:0] sc, input int s, input int g,
                         input int vst, input int vln, input string tag);
        int n, exp_edges, edges;
        n = (vln > vst) ? vln - vst : 0;
        exp_edges = (n > 0) ? n : 1;
        drive(o, ce, d, s2, s1, us, sc, s, g, vst, vln);
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1 && err === 1'b0, {tag, " R9"},
              $sformatf("busy after start actual %b expected 1", busy));
        edges = 0;
        while (!done && edges < 400) begin
            @(posedge clk); @(negedge clk);
            edges++;
        end
        check(edges == exp_edges, {tag, " R9"},
              $sformatf("done latency actual %0d expected %0d", edges, exp_edges));
        check(done && dirty && vclr && !busy, {tag, " R9"},
              $sformatf("pulses d/y/c/b actual %b%b%b%b expected 1110", done, dirty, vclr, busy));
        ref_run(o, ce, d, s2, s1, us, sc, s, vst, vln);
        @(posedge clk); @(negedge clk);
        check(!done && !dirty && !vclr, {tag, " R9"},
              $sformatf("pulse width actual %b%b%b expected 000", done, dirty, vclr));
        compare_all(tag);
    endtask

    task automatic do_reject(input int d, input int s2, input int s1, input bit us,
                             input int s, input int g, input int vln, input string tag);
        drive(1'b0, 1'b1, d, s2, s1, us, 64'h5, s, g, 0, vln);
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        check(err && !busy, tag, $sformatf("err/busy actual %b%b expected 10", err, busy));
        @(posedge clk); @(negedge clk);
        check(!err && !busy && !done, tag, $sformatf("after err actual %b%b%b expected 000", err, busy, done));
        compare_all(tag);
    endtask

    task automatic t_reset();
        check(!busy && !done && !err && !dirty && !vclr, "R1",
              $sformatf("outputs actual %b%b%b%b%b expected 00000", busy, done, err, dirty, vclr));
        for (int r = 0; r < 32; r++) model[r] = '0;
        compare_all("R1 zero file");
    endtask

    task automatic t_add_basic();
        preload();
        do_op(1'b0, 1'b0, 2, 4, 6, 1'b0, 64'd0, 0, 0, 0, 16, "R3 R5 R6 add vv sew8");
    endtask

    task automatic t_adc_carry();
        preload();
        do_op(1'b0, 1'b1, 2, 4, 6, 1'b0, 64'd0, 1, 1, 0, 16, "R3 R6 adc sew16 grp2");
    endtask

    task automatic t_wrap();
        preload();
        model[0] = '1;           tp_write(0, model[0]);
        model[4] = '1;           tp_write(4, model[4]);
        model[6] = '0;           tp_write(6, model[6]);
        do_op(1'b0, 1'b1, 8, 4, 6, 1'b0, 64'd0, 2, 0, 0, 4, "R3 wrap sew32");
        check(model[8] == '0, "R3", $sformatf("wrapped model actual %h expected 0", model[8]));
    endtask

    task automatic t_sbc_scalar();
        preload();
        do_op(1'b1, 1'b0, 8, 12, 0, 1'b1, 64'hDEAD_BEEF_0123_4567, 2, 2, 3, 16,
              "R4 R5 R2 sbc scalar sew32 grp4");
    endtask

    task automatic t_sew64();
        preload();
        do_op(1'b0, 1'b1, 8, 16, 24, 1'b0, 64'd0, 3, 3, 0, 16, "R3 R6 sew64 grp8");
    endtask

    task automatic t_sbc_vv_mid();
        preload();
        do_op(1'b1, 1'b1, 10, 12, 14, 1'b0, 64'd0, 0, 1, 5, 27, "R4 R2 sbc vv sew8 range");
    endtask

    task automatic t_empty();
        preload();
        do_op(1'b0, 1'b1, 2, 4, 6, 1'b0, 64'd0, 0, 0, 5, 5, "R10 vstart eq vl");
        do_op(1'b1, 1'b0, 2, 4, 6, 1'b0, 64'd0, 0, 0, 9, 3, "R10 vstart gt vl");
    endtask

    task automatic t_rejects();
        preload();
        do_reject(0, 4, 6, 1'b0, 0, 0, 4, "R7 vd zero");
        do_reject(3, 4, 6, 1'b0, 0, 1, 4, "R8 vd misaligned");
        do_reject(4, 6, 8, 1'b0, 0, 2, 4, "R8 vs2 misaligned");
        do_reject(4, 8, 5, 1'b0, 0, 2, 4, "R8 vs1 misaligned");
        do_reject(2, 4, 6, 1'b0, 0, 0, 17, "R8 vl over capacity");
    endtask

    task automatic t_busy_ignore();
        int edges;
        bit saw_err;
        logic [VLEN-1:0] old30;
        preload();
        old30 = model[30];
        drive(1'b1, 1'b0, 2, 4, 6, 1'b0, 64'd0, 0, 0, 0, 8);
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        @(posedge clk); @(negedge clk);
        drive(1'b0, 1'b1, 20, 24, 28, 1'b0, 64'd0, 0, 0, 0, 16);
        start = 1'b1;
        tp_we = 1'b1; tp_addr = 5'd30; tp_wdata = ~old30;
        @(posedge clk); @(negedge clk);
        start = 1'b0; tp_we = 1'b0;
        saw_err = err;
        edges = 2;
        while (!done && edges < 400) begin
            @(posedge clk); @(negedge clk);
            edges++;
            saw_err = saw_err | err;
        end
        check(edges == 8 && !saw_err, "R11",
              $sformatf("latency/err actual %0d/%b expected 8/0", edges, saw_err));
        ref_run(1'b1, 1'b0, 2, 4, 6, 1'b0, 64'd0, 0, 0, 8);
        @(posedge clk); @(negedge clk);
        check(!busy, "R11", $sformatf("busy after ignore actual %b expected 0", busy));
        compare_all("R11 R12 busy-time start and side write dropped");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        t_reset();
        t_add_basic();
        t_adc_carry();
        t_wrap();
        t_sbc_scalar();
        t_sew64();
        t_sbc_vv_mid();
        t_empty();
        t_rejects();
        t_busy_ignore();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        check(1'b0, "watchdog", "run hung actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule